// File: doc/BRIEF.md
# Partitioned SIMD Integer Add/Subtract Unit

This unit adds or subtracts two 64-bit operands that are treated as a packed group of independent integer lanes. The lane width is chosen per operation: 8, 16 or 32 bits, which gives 8, 4 or 2 lanes. Every lane is computed at the same time. No carry or borrow crosses from one lane into the next.

Each lane can wrap around modulo its width, or it can saturate at its limits. The lane contents can be read as unsigned or as two's-complement signed values. For every byte position the unit also reports whether the lane that covers that byte overflowed under the chosen reading. The result, the flags and a valid strobe come out of a register one cycle after the operation is presented.

Top module: `simd_lane_alu`

## Requirements
- R1: `lane_sz_i` selects the lane width: 2'b00 gives 8 bits, 2'b01 gives 16 bits, and 2'b10 or 2'b11 give 32 bits. `op_i` 0 selects add and 1 selects subtract (A minus B).
- R2: With `sat_i` low, each lane of `result_o` holds the low lane-width bits of the lane sum or difference. No carry or borrow enters a lane from the lane below it.
- R3: With `sat_i` high and `sgn_i` low, an add whose true sum exceeds the unsigned lane maximum gives a lane of all ones.
- R4: With `sat_i` high and `sgn_i` low, a subtract whose true difference is below zero gives a lane of all zeros.
- R5: With `sat_i` and `sgn_i` high, a lane whose true result falls outside the signed range is clamped. A result above the range gives the most positive value (0 followed by ones). A result below the range gives the most negative value (1 followed by zeros).
- R6: Bit k of `ovf_o` is 1 exactly when the lane that contains byte k (bits 8k+7..8k) overflowed. Overflow is judged as signed when `sgn_i` is 1 and as unsigned when it is 0. The flags are produced the same way whether or not `sat_i` is set.
- R7: `valid_o` equals `valid_i` from one cycle earlier. `result_o` and `ovf_o` are loaded only in a cycle where `valid_i` is 1, and otherwise keep their values.
- R8: A synchronous active-high `rst` clears `valid_o`, `result_o` and `ovf_o` to zero.
- R9: With `sat_i` high, a lane that does not overflow gives the same value as modulo arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 1 | 0 = add, 1 = subtract |
| lane_sz_i | input | 2 | Lane width select |
| sat_i | input | 1 | 1 = saturate, 0 = wrap |
| sgn_i | input | 1 | 1 = signed lanes, 0 = unsigned |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Registered packed result |
| ovf_o | output | 8 | Per-byte overflow flags |

## Verification
The main coincidence is a lane that saturates while a lane next to it wraps or stays inside its range, all in the same cycle. The chain must break at the lane edge, and the clamp must stay inside the one lane that overflowed. The sweep rotates corner values (zero, one, near half-scale, near full-scale) through the lanes with a different phase for each operand. As a result every operation mixes overflowing and quiet lanes under each width, operation, sign and saturate combination. Each lane is compared against a full-precision reference computed in the bench, together with its flag bits.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } alu_op_e;

    typedef enum logic [1:0] {
        LW_8   = 2'b00,
        LW_16  = 2'b01,
        LW_32  = 2'b10,
        LW_32B = 2'b11
    } lane_sz_e;

    // log2 of slices per lane for a width code
    function automatic int unsigned lane_log(input logic [1:0] code);
        case (code)
            2'b00:   return 0;
            2'b01:   return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
    parameter int DATA_W  = 64,
    parameter int SLICE_W = 8,
    localparam int NSLICE = DATA_W / SLICE_W
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              sgn_i,
    input  logic [1:0]        lane_sz_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [NSLICE-1:0] top_ovf_o,
    output logic [NSLICE-1:0] a_msb_o
);
    import simd_alu_pkg::*;

    always_comb begin
        int unsigned lb;
        logic carry;
        logic [SLICE_W:0] part;
        logic [SLICE_W-1:0] bx;
        lb    = 1 << lane_log(lane_sz_i);
        carry = 1'b0;
        sum_o     = '0;
        top_ovf_o = '0;
        a_msb_o   = '0;
        for (int k = 0; k < NSLICE; k++) begin
            // a lane's lowest slice takes the subtract bit, not the neighbour's carry
            if ((k % lb) == 0) begin
                carry = sub_i;
            end
            bx   = b_i[k*SLICE_W +: SLICE_W] ^ {SLICE_W{sub_i}};
            part = {1'b0, a_i[k*SLICE_W +: SLICE_W]} + {1'b0, bx} + {{SLICE_W{1'b0}}, carry};
            sum_o[k*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
            carry = part[SLICE_W];
            a_msb_o[k] = a_i[k*SLICE_W + SLICE_W - 1];
            if ((k % lb) == lb - 1) begin
                if (sgn_i) begin
                    top_ovf_o[k] = (a_i[k*SLICE_W + SLICE_W - 1] == bx[SLICE_W-1]) &&
                                   (part[SLICE_W-1] != a_i[k*SLICE_W + SLICE_W - 1]);
                end else begin
                    top_ovf_o[k] = sub_i ? ~part[SLICE_W] : part[SLICE_W];
                end
            end
        end
    end

endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat #(
    parameter int DATA_W  = 64,
    parameter int SLICE_W = 8,
    localparam int NSLICE = DATA_W / SLICE_W
) (
    input  logic [DATA_W-1:0] sum_i,
    input  logic [NSLICE-1:0] top_ovf_i,
    input  logic [NSLICE-1:0] a_msb_i,
    input  logic [1:0]        lane_sz_i,
    input  logic              sat_i,
    input  logic              sgn_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] res_o,
    output logic [NSLICE-1:0] flag_o
);
    import simd_alu_pkg::*;

    always_comb begin
        int unsigned lb;
        int unsigned t;
        logic lane_ovf;
        logic [SLICE_W-1:0] fill;
        lb     = 1 << lane_log(lane_sz_i);
        res_o  = sum_i;
        flag_o = '0;
        for (int k = 0; k < NSLICE; k++) begin
            t        = unsigned'(k) | (lb - 1);
            lane_ovf = top_ovf_i[t];
            flag_o[k] = lane_ovf;
            if (!sgn_i) begin
                fill = sub_i ? '0 : '1;
            end else if (a_msb_i[t]) begin
                fill = (unsigned'(k) == t) ? {1'b1, {(SLICE_W-1){1'b0}}} : '0;
            end else begin
                fill = (unsigned'(k) == t) ? {1'b0, {(SLICE_W-1){1'b1}}} : '1;
            end
            if (sat_i && lane_ovf) begin
                res_o[k*SLICE_W +: SLICE_W] = fill;
            end
        end
    end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
    parameter int DATA_W  = 64,
    parameter int SLICE_W = 8,
    localparam int NSLICE = DATA_W / SLICE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic              op_i,
    input  logic [1:0]        lane_sz_i,
    input  logic              sat_i,
    input  logic              sgn_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic [NSLICE-1:0] ovf_o
);
    import simd_alu_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
        logic [NSLICE-1:0] flags;
    } out_state_t;

    logic [DATA_W-1:0] sum_raw;
    logic [NSLICE-1:0] top_ovf;
    logic [NSLICE-1:0] a_msb;
    logic [DATA_W-1:0] res_d;
    logic [NSLICE-1:0] flag_d;
    logic              is_sub;
    out_state_t        st_d, st_q;

    assign is_sub = (alu_op_e'(op_i) == OP_SUB);

    simd_seg_adder #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_adder (
        .a_i       (a_i),
        .b_i       (b_i),
        .sub_i     (is_sub),
        .sgn_i     (sgn_i),
        .lane_sz_i (lane_sz_i),
        .sum_o     (sum_raw),
        .top_ovf_o (top_ovf),
        .a_msb_o   (a_msb)
    );

    simd_lane_sat #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_sat (
        .sum_i     (sum_raw),
        .top_ovf_i (top_ovf),
        .a_msb_i   (a_msb),
        .lane_sz_i (lane_sz_i),
        .sat_i     (sat_i),
        .sgn_i     (sgn_i),
        .sub_i     (is_sub),
        .res_o     (res_d),
        .flag_o    (flag_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.res   = res_d;
            st_d.flags = flag_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o  = st_q.valid;
    assign result_o = st_q.res;
    assign ovf_o    = st_q.flags;

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (!valid_o && result_o == '0 && ovf_o == '0));

    p_valid_follow_r7: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);

    p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(result_o) && $stable(ovf_o)));

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !sat_i) |-> (res_d == sum_raw));

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_i && sat_i && flag_d == '0) |-> (res_d == sum_raw));

    p_usat_add_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && sat_i && !sgn_i && !is_sub && flag_d[0]) |-> (res_d[SLICE_W-1:0] == '1));

    p_usat_sub_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && sat_i && !sgn_i && is_sub && flag_d[0]) |-> (res_d[SLICE_W-1:0] == '0));

    p_ssat_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && sat_i && sgn_i && lane_sz_i == LW_8 && flag_d[0]) |->
        (res_d[SLICE_W-1:0] == (a_i[SLICE_W-1] ? {1'b1, {(SLICE_W-1){1'b0}}}
                                                : {1'b0, {(SLICE_W-1){1'b1}}})));

    p_flag_pairs_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && lane_sz_i == LW_16) |-> (flag_d[0] == flag_d[1]));

endmodule

// File: tb/simd_lane_alu_bench.sv
module simd_lane_alu_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic        op_i;
    logic [1:0]  lane_sz_i;
    logic        sat_i;
    logic        sgn_i;
    logic [63:0] a_i;
    logic [63:0] b_i;
    logic        valid_o;
    logic [63:0] result_o;
    logic [7:0]  ovf_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_lane_alu u_simd_lane_alu (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .lane_sz_i(lane_sz_i),
        .sat_i(sat_i), .sgn_i(sgn_i), .a_i(a_i), .b_i(b_i),
        .valid_o(valid_o), .result_o(result_o), .ovf_o(ovf_o)
    );

    function automatic int width_of(input logic [1:0] sz);
        return (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    endfunction

    function automatic longint corner(input int w, input int idx);
        longint half = longint'(1) << (w - 1);
        longint mask = (longint'(1) << w) - 1;
        case (idx % 8)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return half - 1;
            4: return half;
            5: return half + 1;
            6: return mask - 1;
            default: return mask;
        endcase
    endfunction

    task automatic model(input logic [63:0] a, input logic [63:0] b, input logic op,
                         input logic [1:0] sz, input logic sat, input logic sgn,
                         output logic [63:0] r, output logic [7:0] f);
        int w = width_of(sz);
        longint mask = (longint'(1) << w) - 1;
        longint maxs = (longint'(1) << (w - 1)) - 1;
        longint mins = -(longint'(1) << (w - 1));
        r = '0;
        f = '0;
        for (int j = 0; j < 64 / w; j++) begin
            longint ua = longint'((a >> (j * w))) & mask;
            longint ub = longint'((b >> (j * w))) & mask;
            longint full;
            longint lane;
            bit ov;
            if (sgn) begin
                longint sa = (ua >= (longint'(1) << (w - 1))) ? ua - (longint'(1) << w) : ua;
                longint sb = (ub >= (longint'(1) << (w - 1))) ? ub - (longint'(1) << w) : ub;
                full = op ? sa - sb : sa + sb;
                ov   = (full > maxs) || (full < mins);
                lane = (sat && ov) ? ((full > maxs) ? maxs : mins) : full;
            end else begin
                full = op ? ua - ub : ua + ub;
                ov   = (full > mask) || (full < 0);
                lane = (sat && ov) ? (op ? 0 : mask) : full;
            end
            r = r | ((64'(lane) & 64'(mask)) << (j * w));
            if (ov) begin
                for (int k = 0; k < w / 8; k++) f[j * (w / 8) + k] = 1'b1;
            end
        end
    endtask

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // present one operation, then compare at the following falling edge
    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic op,
                          input logic [1:0] sz, input logic sat, input logic sgn, input string tag);
        logic [63:0] er;
        logic [7:0]  ef;
        model(a, b, op, sz, sat, sgn, er, ef);
        valid_i = 1'b1; a_i = a; b_i = b; op_i = op; lane_sz_i = sz; sat_i = sat; sgn_i = sgn;
        @(negedge clk);
        valid_i = 1'b0;
        check64("R7 valid", {63'b0, valid_o}, 64'd1);
        if (!sat)            check64({tag, " R2 result"}, result_o, er);
        else if (ef == 8'h0) check64({tag, " R9 result"}, result_o, er);
        else if (sgn)        check64({tag, " R5 result"}, result_o, er);
        else if (op)         check64({tag, " R4 result"}, result_o, er);
        else                 check64({tag, " R3 result"}, result_o, er);
        check64({tag, " R6 flags"}, {56'b0, ovf_o}, {56'b0, ef});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] hold_r;
        logic [7:0]  hold_f;
        rst = 1'b1; valid_i = 1'b1; op_i = 1'b0; lane_sz_i = 2'b00;
        sat_i = 1'b1; sgn_i = 1'b0; a_i = '1; b_i = '1;
        repeat (3) @(negedge clk);
        // R8: reset state
        check64("R8 valid", {63'b0, valid_o}, 64'd0);
        check64("R8 result", result_o, 64'd0);
        check64("R8 flags", {56'b0, ovf_o}, 64'd0);
        rst = 1'b0; valid_i = 1'b0;
        @(negedge clk);
        check64("R7 idle valid", {63'b0, valid_o}, 64'd0);

        // sweep every mode with rotated lane corner values (R1..R6, R9)
        for (int sz = 0; sz < 3; sz++) begin
            for (int mode = 0; mode < 8; mode++) begin
                for (int i = 0; i < 64; i++) begin
                    int w = width_of(2'(sz));
                    logic [63:0] a = '0;
                    logic [63:0] b = '0;
                    for (int j = 0; j < 64 / w; j++) begin
                        a = a | (64'(corner(w, i + j)) << (j * w));
                        b = b | (64'(corner(w, (i / 8) + 3 * j + 1)) << (j * w));
                    end
                    run_op(a, b, mode[0], 2'(sz), mode[1], mode[2], "R1 sweep");
                end
            end
        end

        // R1: code 2'b11 behaves as 32-bit lanes
        for (int mode = 0; mode < 8; mode++) begin
            run_op(64'h7fff_ffff_ffff_ffff, 64'h0000_0001_8000_0001, mode[0], 2'b11,
                   mode[1], mode[2], "R1 code3");
        end

        // R2: carry must stop at lane edges (0xFF + 0x01 per byte)
        run_op(64'hffff_ffff_ffff_ffff, 64'h0101_0101_0101_0101, 1'b0, 2'b00, 1'b0, 1'b0, "R2 edge");
        run_op(64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, 1'b1, 2'b01, 1'b0, 1'b0, "R2 borrow");

        // pseudo-random mix across modes
        begin
            logic [63:0] lf = 64'h1234_5678_9abc_def1;
            for (int i = 0; i < 400; i++) begin
                logic [63:0] a;
                logic [63:0] b;
                lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
                a  = lf;
                lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
                b  = lf ^ {lf[31:0], lf[63:32]};
                run_op(a, b, lf[3], lf[5:4], lf[6], lf[7], "R6 mix");
            end
        end

        // R7: outputs hold while valid_i is low, even as operands change
        hold_r = result_o;
        hold_f = ovf_o;
        a_i = 64'h0123_4567_89ab_cdef; b_i = 64'hfedc_ba98_7654_3210; sat_i = 1'b0; op_i = 1'b1;
        @(negedge clk);
        check64("R7 hold valid", {63'b0, valid_o}, 64'd0);
        check64("R7 hold result", result_o, hold_r);
        check64("R7 hold flags", {56'b0, ovf_o}, {56'b0, hold_f});

        // R8: reset mid-run clears outputs
        run_op(64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 1'b0, 2'b00, 1'b0, 1'b0, "R8 pre");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check64("R8 late result", result_o, 64'd0);
        check64("R8 late flags", {56'b0, ovf_o}, 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule